// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers single-cycle event pulses from up to eight sources into sticky status bits and reports them through one interrupt output. Each source has an enable bit. The interrupt is asserted while at least one pending status bit has its enable set. A status bit is set whether or not its source is enabled. Only the interrupt output is gated by the enables.

Software reaches the block through a simple strobe interface with a write strobe, a read strobe, an address, and a data bus. A single 16-bit control/status word carries the enables in its upper byte and the pending bits in its lower byte. Reading that word returns the current value and clears every pending bit in the same cycle. A second address holds one polarity bit, which selects whether the asserted interrupt level is high or low.

The interrupt pin is modelled as a data value plus an output enable. When nothing enabled is pending, the output enable is low and the pin is high impedance. When something enabled is pending, the output enable is high and the pin carries the asserted level.

Top module: `irq_ctl_top`

## Requirements
- R1: After a synchronous reset, all of the following hold:
  - all pending bits are 0;
  - all enable bits are 0;
  - the polarity bit is 0 (active low);
  - `irq_oe_o` is 0;
  - `reg_rdata_o` is 0.
- R2: Event line i high on a clock edge sets pending bit i, whatever the state of enable bit i. The bit then stays set until a clearing read.
- R3: A read strobe at address 0 behaves as follows:
  - on the next clock edge, `reg_rdata_o` becomes {enable[7:0], pending[7:0]}, using the values held before that edge;
  - all pending bits are cleared on that same edge;
  - `reg_rdata_o` holds its value when no read strobe is given.
- R4: An event pulse that arrives on the same edge as a clearing read is not lost. Its pending bit is 1 after that edge.
- R5: A write strobe at address 0 loads the enables from `reg_wdata_i[15:8]`. The lower byte of the write data is ignored, so pending bits are unchanged by a write.
- R6: `irq_oe_o` is 1 one clock edge after (pending & enable) is nonzero, and 0 one edge after it is zero.
- R7: The polarity bit is written through `reg_wdata_i[0]` at address 1. While `irq_oe_o` is 1, `irq_o` equals the polarity bit held one edge earlier: 1 means active high, 0 means active low.
- R8: A read strobe at address 1 returns the polarity bit in bit 0 and zeros above it. It does not clear the pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address (0 control/status, 1 polarity) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| evt_i | input | 8 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe_o | output | 1 | Interrupt pin output enable (0 = high impedance) |

## Verification
Directed sequences cover several cases:
- events on disabled sources, which must latch but keep the pin floating;
- a lower-byte write with all ones, which must leave the pending bits untouched;
- enabled events under both polarities;
- a clearing read that coincides with a fresh event.

Each of these cases separates a different fault: a missing or misplaced enable gate, a write that leaks into the status byte, a fixed pin level, and a clear that has priority over a set. A long stretch of random strobes, addresses and event patterns is then compared every cycle against a behavioural model. This exposes ordering faults, such as read data taken after the clear instead of before it.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  // register indices on the strobe interface
  localparam int unsigned CSR_IDX = 0;
  localparam int unsigned POL_IDX = 1;
  // reset value of the polarity bit (0: active low)
  localparam logic POL_RESET = 1'b0;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_i,
  output logic [N_EVT-1:0] pend_o
);
  logic [N_EVT-1:0] pend_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    // set has priority over the read clear so a coinciding event survives
    always_ff @(posedge clk) begin
      if (rst)           pend_q[i] <= 1'b0;
      else if (evt_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i)    pend_q[i] <= 1'b0;
    end

    // R4: an event is always recorded, even during a clearing read
    a_r4_evt_kept : assert property (@(posedge clk) disable iff (rst)
      evt_i[i] |=> pend_q[i]);

    // R2: a pending bit only drops through a clearing read
    a_r2_sticky : assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_i) |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N_EVT  = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned DATA_W = 2 * N_EVT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_EVT-1:0]  pend_i,
  output logic [N_EVT-1:0]  en_o,
  output logic              pol_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              sel_csr, sel_pol;
  logic [N_EVT-1:0]  en_q;
  logic              pol_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel_csr = (addr_i == ADDR_W'(CSR_IDX));
  assign sel_pol = (addr_i == ADDR_W'(POL_IDX));
  assign clr_o   = rd_i && sel_csr;

  always_comb begin
    rd_mux = '0;
    if (sel_csr)      rd_mux = {en_q, pend_i};
    else if (sel_pol) rd_mux[0] = pol_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pol_q   <= POL_RESET;
      rdata_q <= '0;
    end else begin
      // only the upper byte is writable at the control/status index
      if (wr_i && sel_csr) en_q  <= wdata_i[DATA_W-1:N_EVT];
      if (wr_i && sel_pol) pol_q <= wdata_i[0];
      if (rd_i)            rdata_q <= rd_mux;
    end
  end

  // R5: a control/status write lands the upper byte in the enables
  a_r5_en_load : assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_csr) |=> (en_q == $past(wdata_i[DATA_W-1:N_EVT])));

  // R3: read data holds while no read strobe is given
  a_r3_rdata_hold : assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_pin_out.sv
module irq_pin_out #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] pend_i,
  input  logic [N_EVT-1:0] en_i,
  input  logic             pol_i,
  output logic             irq_o,
  output logic             oe_o
);
  logic active;
  logic irq_q, oe_q;

  assign active = |(pend_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      irq_q <= 1'b1;
    end else begin
      oe_q  <= active;
      // drive the asserted level while enabled, its complement otherwise
      irq_q <= active ? pol_i : ~pol_i;
    end
  end

  // R6: enable follows the gated pending set one edge later
  a_r6_oe_on : assert property (@(posedge clk) disable iff (rst)
    (|(pend_i & en_i)) |=> oe_q);
  a_r6_oe_off : assert property (@(posedge clk) disable iff (rst)
    !(|(pend_i & en_i)) |=> !oe_q);

  // R7: the pin shows the programmed level whenever it is driven
  a_r7_level : assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (irq_q == $past(pol_i)));

  assign irq_o = irq_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top #(
  parameter int unsigned N_EVT  = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned DATA_W = 2 * N_EVT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              irq_o,
  output logic              irq_oe_o
);
  logic [N_EVT-1:0] pend;
  logic [N_EVT-1:0] en;
  logic             pol;
  logic             clr;

  irq_evt_latch #(.N_EVT(N_EVT)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_csr_regs #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pend_i  (pend),
    .en_o    (en),
    .pol_o   (pol),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  irq_pin_out #(.N_EVT(N_EVT)) u_pin (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .en_i   (en),
    .pol_i  (pol),
    .irq_o  (irq_o),
    .oe_o   (irq_oe_o)
  );

  // R5: a write with no event and no clearing read leaves pending bits alone
  a_r5_low_byte_ignored : assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && !clr && (evt_i == '0)) |=> (pend == $past(pend)));

  // R8: a polarity read never clears pending bits
  a_r8_no_clear : assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && (reg_addr_i == ADDR_W'(1)) && (evt_i == '0)) |=> (pend == $past(pend)));
endmodule

// File: tb/irq_ctl_top_tb_top.sv
module irq_ctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  evt = '0;
  logic [15:0] rdata;
  logic        irq, oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  logic [7:0]  m_pend, m_en;
  logic        m_pol, m_oe, m_irq;
  logic [15:0] m_rdata;

  always #2 clk = ~clk;   // 250 MHz

  irq_ctl_top dut_i (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .irq_o(irq), .irq_oe_o(oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated from values held before each edge
  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_en <= '0; m_pol <= 1'b0;
      m_oe <= 1'b0; m_irq <= 1'b1; m_rdata <= '0;
    end else begin
      m_oe  <= (m_pend & m_en) != 0;
      m_irq <= ((m_pend & m_en) != 0) ? m_pol : ~m_pol;
      if (rd) m_rdata <= (addr == 2'd0) ? {m_en, m_pend} :
                         (addr == 2'd1) ? {15'd0, m_pol} : 16'd0;
      if (rd && addr == 2'd0) m_pend <= evt;
      else                    m_pend <= m_pend | evt;
      if (wr && addr == 2'd0) m_en  <= wdata[15:8];
      if (wr && addr == 2'd1) m_pol <= wdata[0];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 R8 rdata model", rdata, m_rdata);
      check("R6 oe model", {15'd0, oe}, {15'd0, m_oe});
      if (m_oe) check("R7 level model", {15'd0, irq}, {15'd0, m_irq});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [15:0] d, input logic [7:0] e);
    wr = w; rd = r; addr = a; wdata = d; evt = e;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata reset", rdata, 16'h0000);
    check("R1 oe reset", {15'd0, oe}, 16'd0);

    // R2: disabled events still latch, pin floats
    step(0, 0, 0, 0, 8'h05);
    step(0, 0, 0, 0, 8'h00);
    check("R6 oe disabled", {15'd0, oe}, 16'd0);
    step(0, 1, 0, 0, 8'h00);
    check("R2 latched read", rdata, 16'h0005);
    // R3: cleared by previous read
    step(0, 1, 0, 0, 8'h00);
    check("R3 cleared", rdata, 16'h0000);

    // R5: lower byte ignored
    step(1, 0, 0, 16'hA5FF, 8'h00);
    step(0, 1, 0, 0, 8'h00);
    check("R5 enables only", rdata, 16'hA500);

    // R6 R7: enabled event, active low
    step(0, 0, 0, 0, 8'h20);
    step(0, 0, 0, 0, 8'h00);
    check("R6 oe asserted", {15'd0, oe}, 16'd1);
    check("R7 active low", {15'd0, irq}, 16'd0);

    // R7: switch to active high
    step(1, 0, 1, 16'h0001, 8'h00);
    step(0, 0, 0, 0, 8'h00);
    check("R7 active high", {15'd0, irq}, 16'd1);

    // R8: polarity read does not clear
    step(0, 1, 1, 0, 8'h00);
    check("R8 pol read", rdata, 16'h0001);
    check("R8 still pending", {15'd0, oe}, 16'd1);

    // R4: event coinciding with clearing read
    step(0, 1, 0, 0, 8'h80);
    check("R4 read before clear", rdata, 16'hA520);
    step(0, 1, 0, 0, 8'h00);
    check("R4 event kept", rdata, 16'hA580);
    step(0, 0, 0, 0, 8'h00);
    check("R6 oe released", {15'd0, oe}, 16'd0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] e;
      e = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      step(($urandom % 6) == 0, ($urandom % 4) == 0, 2'($urandom % 3),
           16'($urandom), e);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule